// File: doc/BRIEF.md
# Guard Soak Failure Integrator

This block qualifies and disqualifies one timing reference by integrating short-term failure events over time. Two event inputs arrive each clock: a single-cycle period fault and a coarse frequency fault. Each can be masked on its own. While any unmasked event is present, an internal accumulator climbs by one per clock. When it reaches an upper threshold, the guard-soak failure flag is raised. While no unmasked event is present, the accumulator leaks down by one every `n` clocks. The flag is released only once the accumulator has drained to zero.

The upper threshold sets the disqualification time `td` in clocks. The multiplier `n` stretches the qualification time to `n × td` clocks. A reference therefore has to stay clean for much longer to win back its qualification than it needs to stay bad to lose it. Out of reset the flag is set and the accumulator starts full, so a freshly attached reference must soak for the whole qualification time before it is trusted.

Top module: `gst_integrator`

## Requirements
- R1: During reset and on the first clock after it, `gs_fail` is 1 and the accumulator is full. With no unmasked events, `gs_fail` returns to 0 on exactly the `T × N`-th clock edge after reset, where `T` is the upper threshold and `N` is the multiplier.
- R2: A clock counts as a failing clock when `scm_evt` is 1 and `scm_mask` is 0, or when `cfm_evt` is 1 and `cfm_mask` is 0. Either source alone is enough.
- R3: On each failing clock the accumulator rises by one, and it saturates at the upper threshold. The upper threshold is `td_ticks` (value 0 means 1). `gs_fail` becomes 1 on the edge where the accumulator reaches the threshold, so from an empty accumulator it takes exactly `T` consecutive failing clocks.
- R4: On clocks without a failure the accumulator falls by one once every `N` clocks, where `N` is `qual_mult` (value 0 means 1). Any failing clock restarts this `N`-clock decay interval.
- R5: Once set, `gs_fail` stays at 1 until the accumulator is zero, even while the accumulator is below the threshold. Once clear, it stays at 0 until the accumulator reaches the threshold again.
- R6: An event whose mask bit is 1 has no effect on the accumulator or on `gs_fail`.
- R7: A threshold setting of 0 behaves as a threshold of 1. A multiplier setting of 0 behaves as a multiplier of 1.
- R8: The accumulator never wraps below zero. Quiet clocks at zero leave it at zero, so a following failure starts from one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one integration tick per rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| scm_evt | input | 1 | Single-cycle period failure event |
| cfm_evt | input | 1 | Coarse frequency failure event |
| scm_mask | input | 1 | 1 ignores `scm_evt` |
| cfm_mask | input | 1 | 1 ignores `cfm_evt` |
| td_ticks | input | ACC_W (8) | Upper threshold, the disqualification time in clocks |
| qual_mult | input | N_W (4) | Decay divider `n`; qualification time is `n × td` |
| gs_fail | output | 1 | Guard-soak failure flag |

## Verification
On every cycle, the assertions check several properties:
- The flag rises only after a failing clock and falls only after a quiet clock that leaves the accumulator empty.
- The accumulator never grows on a quiet clock.
- The accumulator stays pinned at zero and at the threshold.
- A failing clock clears the decay interval.

Other behaviour can only be shown by the bench scenarios, which compare against a cycle-level model:
- the exact `T × N` soak time after reset
- the hysteresis band where the flag holds while the accumulator drains
- mask independence per source
- the zero-setting substitutions
- the absence of wraparound

// File: rtl/gst_pkg.sv
package gst_pkg;

    // Action applied to the accumulator on one clock.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } gst_step_e;

endpackage

// File: rtl/gst_event_gate.sv
module gst_event_gate #(
    parameter int SRC_N = 2
) (
    input  logic [SRC_N-1:0] evt_i,
    input  logic [SRC_N-1:0] mask_i,
    output logic             active_o
);
    logic [SRC_N-1:0] live;

    for (genvar g = 0; g < SRC_N; g++) begin : g_src
        assign live[g] = evt_i[g] & ~mask_i[g];
    end

    always_comb begin
        active_o = |live;
    end
endmodule

// File: rtl/gst_decay_pacer.sv
module gst_decay_pacer #(
    parameter int N_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           active_i,
    input  logic [N_W-1:0] mult_i,
    output logic           step_o,
    output logic [N_W-1:0] cnt_o
);
    localparam int CW = N_W + 1;

    typedef struct packed {
        logic [N_W-1:0] cnt;
    } pacer_t;

    pacer_t st_d, st_q;
    logic [CW-1:0] n_eff;
    logic [CW-1:0] cnt_inc;

    always_comb begin
        n_eff   = (mult_i == '0) ? CW'(1) : {1'b0, mult_i};
        cnt_inc = {1'b0, st_q.cnt} + CW'(1);
        st_d    = st_q;
        step_o  = 1'b0;
        if (active_i) begin
            st_d.cnt = '0;
        end else if (cnt_inc >= n_eff) begin
            st_d.cnt = '0;
            step_o   = 1'b1;
        end else begin
            st_d.cnt = cnt_inc[N_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/gst_accum.sv
module gst_accum
    import gst_pkg::*;
#(
    parameter int ACC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  gst_step_e        step_i,
    input  logic [ACC_W-1:0] limit_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             fail_o
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             fail;
    } acc_t;

    acc_t st_d, st_q;
    logic [ACC_W-1:0] base;

    always_comb begin
        // A threshold lowered below the held level pulls the level down to it.
        base = (st_q.acc > limit_i) ? limit_i : st_q.acc;
        st_d = st_q;
        unique case (step_i)
            STEP_UP:   st_d.acc = (base < limit_i) ? base + ACC_W'(1) : limit_i;
            STEP_DOWN: st_d.acc = (base != '0) ? base - ACC_W'(1) : '0;
            default:   st_d.acc = base;
        endcase
        if (st_d.acc >= limit_i)  st_d.fail = 1'b1;
        else if (st_d.acc == '0)  st_d.fail = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.acc  <= '1;
            st_q.fail <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o  = st_q.acc;
    assign fail_o = st_q.fail;
endmodule

// File: rtl/gst_integrator.sv
module gst_integrator
    import gst_pkg::*;
#(
    parameter int ACC_W = 8,
    parameter int N_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scm_evt,
    input  logic             cfm_evt,
    input  logic             scm_mask,
    input  logic             cfm_mask,
    input  logic [ACC_W-1:0] td_ticks,
    input  logic [N_W-1:0]   qual_mult,
    output logic             gs_fail
);
    localparam int SRC_N = 2;

    logic             active;
    logic             decay;
    logic [N_W-1:0]   pace_cnt;
    logic [ACC_W-1:0] limit;
    logic [ACC_W-1:0] acc_val;
    gst_step_e        step;

    gst_event_gate #(.SRC_N(SRC_N)) u_gate (
        .evt_i   ({cfm_evt, scm_evt}),
        .mask_i  ({cfm_mask, scm_mask}),
        .active_o(active)
    );

    gst_decay_pacer #(.N_W(N_W)) u_pace (
        .clk     (clk),
        .rst_n   (rst_n),
        .active_i(active),
        .mult_i  (qual_mult),
        .step_o  (decay),
        .cnt_o   (pace_cnt)
    );

    always_comb begin
        limit = (td_ticks == '0) ? ACC_W'(1) : td_ticks;
        if (active)     step = STEP_UP;
        else if (decay) step = STEP_DOWN;
        else            step = STEP_HOLD;
    end

    gst_accum #(.ACC_W(ACC_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step),
        .limit_i(limit),
        .acc_o  (acc_val),
        .fail_o (gs_fail)
    );
endmodule

// File: rtl/gst_integrator_chk.sv
module gst_integrator_chk #(
    parameter int ACC_W = 8,
    parameter int N_W   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             active,
    input logic [ACC_W-1:0] acc,
    input logic [ACC_W-1:0] limit,
    input logic [N_W-1:0]   pace_cnt,
    input logic             fail
);
    // R3
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> $past(active));

    // R5
    fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fail) |-> ($past(!active) && acc == '0));

    // R6
    quiet_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> acc <= $past(acc));

    // R8
    floor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && acc == '0) |=> acc == '0);

    // R3
    ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && acc >= limit) |=> acc == $past(limit));

    // R4
    pace_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> pace_cnt == '0);
endmodule

bind gst_integrator gst_integrator_chk #(.ACC_W(ACC_W), .N_W(N_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (active),
    .acc     (acc_val),
    .limit   (limit),
    .pace_cnt(pace_cnt),
    .fail    (gs_fail)
);

// File: tb/gst_integrator_test.sv
module gst_integrator_test;
    localparam int ACC_W = 8;
    localparam int N_W   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scm_evt = 1'b0, cfm_evt = 1'b0, scm_mask = 1'b0, cfm_mask = 1'b0;
    logic [ACC_W-1:0] td_ticks = 8'd4;
    logic [N_W-1:0]   qual_mult = 4'd3;
    logic gs_fail;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Behavioural model state
    int m_acc = 255;
    int m_pace = 0;
    bit m_flag = 1'b1;

    always #4 clk = ~clk;

    gst_integrator #(.ACC_W(ACC_W), .N_W(N_W)) uut (
        .clk(clk), .rst_n(rst_n), .scm_evt(scm_evt), .cfm_evt(cfm_evt),
        .scm_mask(scm_mask), .cfm_mask(cfm_mask), .td_ticks(td_ticks),
        .qual_mult(qual_mult), .gs_fail(gs_fail)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_acc = 255; m_pace = 0; m_flag = 1'b1;
        end else begin
            int up, n, a;
            bit act;
            act = (scm_evt && !scm_mask) || (cfm_evt && !cfm_mask);
            up  = (td_ticks == 0) ? 1 : int'(td_ticks);
            n   = (qual_mult == 0) ? 1 : int'(qual_mult);
            a   = (m_acc > up) ? up : m_acc;
            if (act) begin
                m_pace = 0;
                a = (a < up) ? a + 1 : up;
            end else if (m_pace + 1 >= n) begin
                m_pace = 0;
                if (a > 0) a = a - 1;
            end else begin
                m_pace = m_pace + 1;
            end
            m_acc = a;
            if (a >= up) m_flag = 1'b1;
            else if (a == 0) m_flag = 1'b0;
        end
    end

    // Per-cycle comparison against the model (R3, R4, R5)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (gs_fail !== m_flag) begin
                errors++;
                $display("FAIL model R5: gs_fail=%0b expected=%0b", gs_fail, m_flag);
            end
        end
    end

    task automatic check(input string req, input logic exp);
        checks++;
        if (gs_fail !== exp) begin
            errors++;
            $display("FAIL %s: gs_fail=%0b expected=%0b", req, gs_fail, exp);
        end
    endtask

    task automatic cyc(input logic s, input logic c, input int count);
        for (int i = 0; i < count; i++) begin
            scm_evt = s; cfm_evt = c;
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr;
        repeat (3) @(negedge clk);
        check("R1 flag during reset", 1'b1);
        rst_n = 1'b1;
        cyc(0, 0, 1);
        check("R1 flag after first clock", 1'b1);
        cyc(0, 0, 10);
        check("R1 soak T*N-1", 1'b1);
        cyc(0, 0, 1);
        check("R1 soak T*N", 1'b0);

        scm_mask = 1'b1;
        cyc(1, 0, 20);
        check("R6 masked scm", 1'b0);
        scm_mask = 1'b0;
        cyc(0, 1, 3);
        check("R3 three of four failures", 1'b0);
        cyc(0, 1, 1);
        check("R3 fourth failure", 1'b1);
        cyc(0, 0, 11);
        check("R4 decay one short", 1'b1);
        cyc(0, 0, 1);
        check("R4 decay to zero", 1'b0);

        cyc(1, 1, 4);
        check("R3 both sources", 1'b1);
        cyc(0, 0, 6);
        check("R5 hold in band", 1'b1);
        cyc(1, 0, 1);
        cyc(0, 0, 2);
        check("R4 pacer restart", 1'b1);
        cyc(0, 0, 9);
        check("R5 clear at zero", 1'b0);

        td_ticks = 8'd2; cfm_mask = 1'b1;
        cyc(0, 1, 5);
        check("R6 masked cfm", 1'b0);
        cyc(1, 0, 2);
        check("R2 scm alone", 1'b1);
        cfm_mask = 1'b0;

        td_ticks = 8'd0; qual_mult = 4'd0;
        cyc(0, 0, 2);
        check("R7 clear with n=0", 1'b0);
        cyc(1, 0, 1);
        check("R7 one failure with td=0", 1'b1);
        cyc(0, 0, 1);
        check("R7 one quiet with n=0", 1'b0);

        td_ticks = 8'd2; qual_mult = 4'd1;
        cyc(0, 0, 5);
        cyc(0, 1, 1);
        check("R8 no wrap single failure", 1'b0);
        cyc(0, 1, 1);
        check("R8 second failure", 1'b1);

        td_ticks = 8'd6; qual_mult = 4'd2;
        lfsr = 8'hA5;
        for (int k = 0; k < 3000; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            scm_mask = (k % 700) > 500;
            cyc(lfsr[0] & lfsr[1], lfsr[2] & lfsr[3] & lfsr[4], 1);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule